// File: doc/BRIEF.md
# Pin Edge-Event Interrupt Controller

This block watches a port of asynchronous input pins and records, per pin, when a pin makes a transition that software has selected. Each pin has two independent selects, one for low-to-high and one for high-to-low. Setting both selects makes either edge count, and clearing both makes the pin silent. Every recorded transition sets a sticky per-pin flag. A registered interrupt line is high while any flag is set.

A single control bit arms or disarms detection for the whole port. Software programs the edge selects, arms the block, and then services the interrupt. To service it, software reads the flag word and writes zeros to the bits it has handled. All access goes through a small synchronous register bus with four word addresses and read data that is registered.

Pins cross into the clock domain through a synchronizer chain. Edges are found by comparing each synchronized sample with the one taken a cycle earlier. The earlier sample is refreshed every cycle, even while the block is disarmed, so arming the block never reports a transition that happened before it was armed.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst` is high and after it falls, the control, rise-select, fall-select and flag words read 0, and `irq` is 0.
- R2: When the block is armed and the rise-select bit of pin n is 1, a 0-to-1 change on `pin_i[n]` sets flag bit n. It reaches `irq` on the fourth rising clock edge after the change (two synchronizer edges, one flag edge, one interrupt edge).
- R3: When the block is armed and the fall-select bit of pin n is 1, a 1-to-0 change on `pin_i[n]` sets flag bit n.
- R4: A pin with both select bits set flags on either edge. A pin with both select bits clear never sets its flag, and a change on such a pin leaves every flag unchanged.
- R5: Control bit 0 arms detection. While it is 0, no flag bit is set. A pin that changed while the block was disarmed does not set a flag when the block is armed later.
- R6: Flags are sticky. A bus write to the flag word clears each bit written as 0 and keeps each bit written as 1. Nothing else clears a flag.
- R7: When a detected edge on pin n and a flag-word write of 0 to bit n land on the same clock edge, bit n ends up set.
- R8: `irq` is registered: it is 1 on the clock edge after any flag bit is 1, and 0 on the clock edge after all flags are 0.
- R9: The word addresses are 0 for control, 1 for rise-select, 2 for fall-select and 3 for flags. A read returns the word on `bus_rdata` after the next rising edge. Control bits 15..1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PINS | Raw asynchronous pin levels |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered OR of all flags |

## Verification
The bench builds the block at its defaults: 16 pins, a 16-bit data word and a two-stage synchronizer. At that size every pin can be swept against all four select combinations and both edge directions, and each case's expected flag word is computed as a single shifted bit or zero. Directed sequences then cover the interrupt latency counted in edges, the clear that collides with an edge, the arming order and the register map.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pcn_sync.sv
module pcn_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcn_edge.sv
module pcn_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] evt_o
);
  // Previous sample follows the input even while disarmed, so arming
  // compares against a fresh value and reports no stale transition.
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic went_up, went_down;
      assign went_up   =  sync_i[i] & ~prev_q[i];
      assign went_down = ~sync_i[i] &  prev_q[i];
      assign evt_o[i]  = arm_i & ((went_up & rise_sel_i[i]) | (went_down & fall_sel_i[i]));
    end
  endgenerate
endmodule

// File: rtl/pcn_regs.sv
module pcn_regs
  import pcn_pkg::*;
#(
  parameter int W      = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [W-1:0]      evt_i,
  output logic              arm_o,
  output logic [W-1:0]      rise_o,
  output logic [W-1:0]      fall_o,
  output logic [W-1:0]      flag_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              arm_q;
  logic [W-1:0]      rise_q, fall_q, flag_q, flag_d;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              flag_wr;

  function automatic logic [DATA_W-1:0] widen(input logic [W-1:0] v);
    logic [DATA_W-1:0] t;
    t = '0;
    t[W-1:0] = v;
    return t;
  endfunction

  assign flag_wr = bus_we && (reg_sel_e'(bus_addr) == SEL_FLAG);

  // Written zeros clear; new events win over a clear in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (flag_wr) flag_d = flag_q & bus_wdata[W-1:0];
    flag_d = flag_d | evt_i;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(bus_addr))
      SEL_CTRL: rd_mux[0] = arm_q;
      SEL_RISE: rd_mux = widen(rise_q);
      SEL_FALL: rd_mux = widen(fall_q);
      SEL_FLAG: rd_mux = widen(flag_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      rise_q  <= '0;
      fall_q  <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= |flag_q;
      if (bus_we) begin
        unique case (reg_sel_e'(bus_addr))
          SEL_CTRL: arm_q  <= bus_wdata[0];
          SEL_RISE: rise_q <= bus_wdata[W-1:0];
          SEL_FALL: fall_q <= bus_wdata[W-1:0];
          default:  ;
        endcase
      end
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign arm_o   = arm_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int N_PINS      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [N_PINS-1:0] pin_sync, evt, rise_q, fall_q, flag_q;
  logic              arm_q;

  pcn_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync)
  );

  pcn_edge #(.W(N_PINS)) u_edge (
    .clk(clk), .rst(rst), .arm_i(arm_q), .sync_i(pin_sync),
    .rise_sel_i(rise_q), .fall_sel_i(fall_q), .evt_o(evt)
  );

  pcn_regs #(.W(N_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_i(evt),
    .arm_o(arm_q), .rise_o(rise_q), .fall_o(fall_q), .flag_o(flag_q),
    .rdata_o(bus_rdata), .irq_o(irq)
  );
endmodule

// File: rtl/pcn_check.sv
module pcn_check #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic         arm_q,
  input logic [N-1:0] rise_q,
  input logic [N-1:0] fall_q,
  input logic [N-1:0] flag_q,
  input logic         irq
);
  // R1: reset leaves flags and interrupt quiet
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (flag_q == '0) && !irq);

  // R8: interrupt follows the flags one edge later
  a_r8_irq_high: assert property (@(posedge clk) disable iff (rst) (|flag_q) |=> irq);
  a_r8_irq_low:  assert property (@(posedge clk) disable iff (rst) (flag_q == '0) |=> !irq);

  // R5: no new flag while disarmed
  a_r5_disarmed: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> ((flag_q & ~$past(flag_q)) == '0));

  // R4: a pin with no edge selected never gains a flag
  a_r4_unselected: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~($past(rise_q) | $past(fall_q))) == '0));

  // R6: flags only drop through a flag-word write
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == 2'd3) |=> ((~flag_q & $past(flag_q)) == '0));
endmodule

bind pin_change_irq pcn_check #(.N(N_PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .arm_q(arm_q), .rise_q(rise_q), .fall_q(fall_q), .flag_q(flag_q), .irq(irq)
);

// File: tb/sim_pin_change_irq.sv
module sim_pin_change_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            checks = 0, errors = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.N_PINS(NP), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    idle(5);
    check("R1 irq in reset", DW'(irq), '0);
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reset word", v, '0);
    end
    check("R1 irq after reset", DW'(irq), '0);

    // R9 register map
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R9 ctrl upper bits zero", v, 16'h0001);
    wr(2'd1, 16'hA5A5); rd(2'd1, v); check("R9 rise word", v, 16'hA5A5);
    wr(2'd2, 16'h5A5A); rd(2'd2, v); check("R9 fall word", v, 16'h5A5A);
    rd(2'd3, v); check("R9 flag word untouched", v, '0);

    // Sweep: R2, R3, R4 over every pin, select combination and edge direction
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [DW-1:0] expv;
          logic [DW-1:0] bit_p;
          bit_p = DW'(1) << p;
          wr(2'd1, '0); wr(2'd2, '0);
          @(negedge clk); pins[p] = (dir == 1);
          idle(4);
          wr(2'd1, m[0] ? bit_p : '0);
          wr(2'd2, m[1] ? bit_p : '0);
          idle(2);
          @(negedge clk); pins[p] = (dir == 0);
          idle(6);
          expv = ((dir == 0 && m[0]) || (dir == 1 && m[1])) ? bit_p : '0;
          rd(2'd3, v);
          check((m == 0) ? "R4 no select" : (m == 3) ? "R4 both selects" :
                (dir == 0) ? "R2 rising" : "R3 falling", v, expv);
          check("R8 irq matches flags", DW'(irq), DW'(expv != '0));
          wr(2'd3, '0);
          idle(2);
          check("R8 irq drops after clear", DW'(irq), '0);
          @(negedge clk); pins[p] = 1'b0;
          wr(2'd1, '0); wr(2'd2, '0);
          idle(4);
        end
      end
    end

    // R2 latency in edges
    wr(2'd3, '0); wr(2'd1, 16'h0007); wr(2'd2, '0); idle(4);
    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R2 irq not before fourth edge", DW'(irq), '0);
    @(posedge clk);
    @(negedge clk); check("R2 irq on fourth edge", DW'(irq), 16'h0001);

    // R7 edge on pin 2 collides with a clear of all flags
    @(negedge clk); pins[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = '0;
    @(negedge clk); we = 1'b0;
    rd(2'd3, v); check("R7 event beats clear", v, 16'h0004);

    // R6 ones keep, zeros clear
    wr(2'd3, 16'hFFFF); rd(2'd3, v); check("R6 ones keep flags", v, 16'h0004);
    wr(2'd3, 16'hFFFB); rd(2'd3, v); check("R6 zero clears flag", v, '0);

    // R5 disarmed and arming order
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF); wr(2'd0, '0);
    @(negedge clk); pins[3] = 1'b1; idle(4);
    @(negedge clk); pins[4] = 1'b1; idle(4);
    @(negedge clk); pins[4] = 1'b0; idle(4);
    rd(2'd3, v); check("R5 nothing while disarmed", v, '0);
    wr(2'd0, 16'h0001); idle(6);
    rd(2'd3, v); check("R5 no stale edge on arming", v, '0);
    check("R5 irq quiet on arming", DW'(irq), '0);
    @(negedge clk); pins[3] = 1'b0; idle(6);
    rd(2'd3, v); check("R5 armed edge captured", v, 16'h0008);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule